// File: doc/BRIEF.md
# Two-Argument Arctangent Front End

This block sits ahead of a single-precision two-argument arctangent datapath. It accepts a pair of binary32 operands, `y` and `x`, and sorts every pair into one of two outcomes. If either operand is NaN, infinite or zero, the whole answer is already known. The block then emits that final binary32 result and the core does no work.

Otherwise the operands are finite and nonzero. The block then emits a reduction command for the downstream divider, core evaluator and adder. The command carries the two magnitudes in numerator/denominator order, so that their quotient lies in [0,1]. It also carries a binary32 offset constant, a flag that selects whether the core result is added to that offset or subtracted from it, and the sign of the final answer.

Accepted operands appear on the output one cycle later. The input and the output each use a valid/ready handshake, with one registered stage between them.

Top module: `atan2_fe`

## Requirements
- R1: If x is NaN the final result is x; otherwise, if y is NaN, the final result is y. In both cases bit 22 (the quiet bit) is forced to 1 and every other bit, payload and sign included, is kept.
- R2: If x is +infinity, the final result is pi/4 (0x3F490FDB) when y is infinite and zero when y is finite. In both cases the sign bit is copied from y.
- R3: If x is -infinity, the final result is 3pi/4 (0x4016CBE4) when y is infinite and pi (0x40490FDB) when y is finite. In both cases the sign bit is copied from y.
- R4: If x is finite and y is infinite, the final result is pi/2 (0x3FC90FDB) with the sign of y.
- R5: If x is a zero of either sign and y is finite and nonzero, the final result is pi/2 with the sign of y.
- R6: If y is a zero and x is finite, the final result has the sign of y. Its magnitude is zero when x is positive or +0, and pi when x is negative or -0.
- R7: For finite nonzero operands with |y| <= |x| (compared as 31-bit magnitudes, so that equal magnitudes land here), `out_swap`=0, `out_num`=|y| and `out_den`=|x|. For x > 0, the offset is 0 and `out_sub`=0. For x < 0, the offset is pi and `out_sub`=1.
- R8: For finite nonzero operands with |y| > |x|, `out_swap`=1, `out_num`=|x|, `out_den`=|y` and the offset is pi/2. `out_sub`=1 when x > 0 and 0 when x < 0.
- R9: A command (`out_final`=0) sets `out_neg` to the sign of y, keeps `out_num` <= `out_den`, and handles subnormals as ordinary nonzero values. A final result (`out_final`=1) zeroes `out_swap`, `out_sub`, `out_neg`, `out_offset`, `out_num` and `out_den`. A command zeroes `out_result`.
- R10: `in_ready` is high whenever the output register is empty or `out_ready` is high. An accepted pair is presented with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, every output field holds steady.
- R11: While reset is asserted, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken |
| in_y | input | 32 | Binary32 y operand |
| in_x | input | 32 | Binary32 x operand |
| out_ready | input | 1 | Consumer takes the output |
| out_valid | output | 1 | Output fields hold a result |
| out_final | output | 1 | 1: out_result is the answer; 0: the command fields apply |
| out_result | output | 32 | Final binary32 result for special operands |
| out_swap | output | 1 | 0: ratio is \|y\|/\|x\|; 1: ratio is \|x\|/\|y\| |
| out_sub | output | 1 | 1: offset minus core value; 0: offset plus core value |
| out_neg | output | 1 | Sign to apply to the finished answer |
| out_offset | output | 32 | Binary32 offset constant (0, pi/2 or pi) |
| out_num | output | 31 | Ratio numerator magnitude |
| out_den | output | 31 | Ratio denominator magnitude |

## Verification
Every ordered pair drawn from a sixteen-value set is applied. The set holds both zeros, both infinities, quiet and signalling NaNs with payloads and signs, small and large normals of both signs, subnormals of both signs and the largest finite value. The sweep therefore reaches each branch of the special-case priority. NaN-versus-infinity pairs show which operand's NaN wins. Zero-versus-zero pairs separate the y-zero rule from the x-zero rule by the sign of x. Equal magnitudes such as 2.0 against -2.0 show how ties fall between the direct and swapped reductions, and subnormal-versus-normal pairs show that tiny values are not flushed. A back-pressure sequence holds the output, shows the input stalled, and then shows the held and queued pairs leaving in order.

// File: rtl/atan2_fe_pkg.sv
package atan2_fe_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int MAG_W  = WORD_W - 1;

    // round-to-nearest binary32 encodings of the angle constants
    localparam logic [WORD_W-1:0] K_PI      = 32'h40490FDB;
    localparam logic [WORD_W-1:0] K_HALF_PI = 32'h3FC90FDB;
    localparam logic [WORD_W-1:0] K_QTR_PI  = 32'h3F490FDB;
    localparam logic [WORD_W-1:0] K_3QTR_PI = 32'h4016CBE4;

    typedef enum logic [1:0] {
        OPC_ZERO,
        OPC_FIN,
        OPC_INF,
        OPC_NAN
    } opclass_e;

    typedef struct packed {
        logic              sign;
        opclass_e          cls;
        logic [WORD_W-1:0] raw;
    } opinfo_t;

    typedef struct packed {
        logic              is_final;
        logic [WORD_W-1:0] result;
        logic              swap;
        logic              sub;
        logic              neg;
        logic [WORD_W-1:0] offset;
        logic [MAG_W-1:0]  num;
        logic [MAG_W-1:0]  den;
    } fe_out_t;
endpackage

// File: rtl/atan2_fe_classify.sv
module atan2_fe_classify
    import atan2_fe_pkg::*;
(
    input  logic [WORD_W-1:0] op_i,
    output opinfo_t           info_o
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = op_i[WORD_W-2:MAN_W];
    assign man_f = op_i[MAN_W-1:0];

    always_comb begin
        info_o.sign = op_i[WORD_W-1];
        info_o.raw  = op_i;
        if (exp_f == '1) begin
            info_o.cls = (man_f == '0) ? OPC_INF : OPC_NAN;
        end else if (exp_f == '0 && man_f == '0) begin
            info_o.cls = OPC_ZERO;
        end else begin
            // subnormals stay on the finite path
            info_o.cls = OPC_FIN;
        end
    end
endmodule

// File: rtl/atan2_fe_special.sv
module atan2_fe_special
    import atan2_fe_pkg::*;
(
    input  opinfo_t           y_i,
    input  opinfo_t           x_i,
    output logic              hit_o,
    output logic [WORD_W-1:0] res_o
);
    localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (MAN_W - 1);

    logic [MAG_W-1:0] mag_sel;

    always_comb begin
        hit_o   = 1'b1;
        mag_sel = '0;
        res_o   = '0;
        if (x_i.cls == OPC_NAN) begin
            res_o = x_i.raw | QUIET_BIT;
        end else if (y_i.cls == OPC_NAN) begin
            res_o = y_i.raw | QUIET_BIT;
        end else if (x_i.cls == OPC_INF) begin
            if (x_i.sign) begin
                mag_sel = (y_i.cls == OPC_INF) ? K_3QTR_PI[MAG_W-1:0] : K_PI[MAG_W-1:0];
            end else begin
                mag_sel = (y_i.cls == OPC_INF) ? K_QTR_PI[MAG_W-1:0] : '0;
            end
            res_o = {y_i.sign, mag_sel};
        end else if (y_i.cls == OPC_INF) begin
            res_o = {y_i.sign, K_HALF_PI[MAG_W-1:0]};
        end else if (x_i.cls == OPC_ZERO && y_i.cls != OPC_ZERO) begin
            res_o = {y_i.sign, K_HALF_PI[MAG_W-1:0]};
        end else if (y_i.cls == OPC_ZERO) begin
            mag_sel = x_i.sign ? K_PI[MAG_W-1:0] : '0;
            res_o   = {y_i.sign, mag_sel};
        end else begin
            hit_o = 1'b0;
        end
    end
endmodule

// File: rtl/atan2_fe_reduce.sv
module atan2_fe_reduce
    import atan2_fe_pkg::*;
(
    input  logic [MAG_W-1:0]  y_mag_i,
    input  logic [MAG_W-1:0]  x_mag_i,
    input  logic              y_neg_i,
    input  logic              x_neg_i,
    output logic              swap_o,
    output logic              sub_o,
    output logic              neg_o,
    output logic [WORD_W-1:0] off_o,
    output logic [MAG_W-1:0]  num_o,
    output logic [MAG_W-1:0]  den_o
);
    always_comb begin
        // magnitude order of binary32 equals integer order of its low 31 bits
        swap_o = (y_mag_i > x_mag_i);
        neg_o  = y_neg_i;
        if (swap_o) begin
            num_o = x_mag_i;
            den_o = y_mag_i;
            off_o = K_HALF_PI;
            sub_o = ~x_neg_i;
        end else begin
            num_o = y_mag_i;
            den_o = x_mag_i;
            off_o = x_neg_i ? K_PI : '0;
            sub_o = x_neg_i;
        end
    end
endmodule

// File: rtl/atan2_fe.sv
module atan2_fe
    import atan2_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_y,
    input  logic [WORD_W-1:0] in_x,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_final,
    output logic [WORD_W-1:0] out_result,
    output logic              out_swap,
    output logic              out_sub,
    output logic              out_neg,
    output logic [WORD_W-1:0] out_offset,
    output logic [MAG_W-1:0]  out_num,
    output logic [MAG_W-1:0]  out_den
);
    localparam int N_OPS = 2;  // index 0: y, index 1: x

    typedef struct packed {
        logic    vld;
        fe_out_t pay;
    } stage_t;

    logic [WORD_W-1:0] opnd [N_OPS];
    opinfo_t           info [N_OPS];

    assign opnd[0] = in_y;
    assign opnd[1] = in_x;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        atan2_fe_classify u_cls (
            .op_i   (opnd[g]),
            .info_o (info[g])
        );
    end

    logic              sp_hit;
    logic [WORD_W-1:0] sp_res;

    atan2_fe_special u_special (
        .y_i   (info[0]),
        .x_i   (info[1]),
        .hit_o (sp_hit),
        .res_o (sp_res)
    );

    logic              rd_swap, rd_sub, rd_neg;
    logic [WORD_W-1:0] rd_off;
    logic [MAG_W-1:0]  rd_num, rd_den;

    atan2_fe_reduce u_reduce (
        .y_mag_i (in_y[MAG_W-1:0]),
        .x_mag_i (in_x[MAG_W-1:0]),
        .y_neg_i (in_y[WORD_W-1]),
        .x_neg_i (in_x[WORD_W-1]),
        .swap_o  (rd_swap),
        .sub_o   (rd_sub),
        .neg_o   (rd_neg),
        .off_o   (rd_off),
        .num_o   (rd_num),
        .den_o   (rd_den)
    );

    stage_t st_d, st_q;
    logic   take;

    assign in_ready = ~st_q.vld | out_ready;
    assign take     = in_valid & in_ready;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.vld = 1'b1;
            st_d.pay = '0;
            if (sp_hit) begin
                st_d.pay.is_final = 1'b1;
                st_d.pay.result   = sp_res;
            end else begin
                st_d.pay.swap   = rd_swap;
                st_d.pay.sub    = rd_sub;
                st_d.pay.neg    = rd_neg;
                st_d.pay.offset = rd_off;
                st_d.pay.num    = rd_num;
                st_d.pay.den    = rd_den;
            end
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_final  = st_q.pay.is_final;
    assign out_result = st_q.pay.result;
    assign out_swap   = st_q.pay.swap;
    assign out_sub    = st_q.pay.sub;
    assign out_neg    = st_q.pay.neg;
    assign out_offset = st_q.pay.offset;
    assign out_num    = st_q.pay.num;
    assign out_den    = st_q.pay.den;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_final) && $stable(out_result)
            && $stable(out_offset) && $stable(out_num) && $stable(out_den));

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_final |-> out_num <= out_den);

    p_swap_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_final && out_swap |-> out_offset == K_HALF_PI);

    p_direct_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_final && !out_swap |->
            (out_offset == '0 && !out_sub) || (out_offset == K_PI && out_sub));

    p_nan_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_final && out_result[WORD_W-2:MAN_W] == '1
            && out_result[MAN_W-1:0] != '0 |-> out_result[MAN_W-1]);
endmodule

// File: tb/atan2_fe_tb.sv
`timescale 1ns/1ps
module atan2_fe_tb;
    localparam int VW = 131;

    logic        clk = 1'b0;
    logic        rst_n, in_valid, in_ready, out_ready, out_valid;
    logic [31:0] in_y, in_x;
    logic        out_final, out_swap, out_sub, out_neg;
    logic [31:0] out_result, out_offset;
    logic [30:0] out_num, out_den;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    atan2_fe u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_y(in_y), .in_x(in_x), .out_ready(out_ready), .out_valid(out_valid),
        .out_final(out_final), .out_result(out_result), .out_swap(out_swap),
        .out_sub(out_sub), .out_neg(out_neg), .out_offset(out_offset),
        .out_num(out_num), .out_den(out_den)
    );

    function automatic logic [31:0] val(int i);
        case (i)
            0:  return 32'h00000000;
            1:  return 32'h80000000;
            2:  return 32'h7F800000;
            3:  return 32'hFF800000;
            4:  return 32'h7FC00000;
            5:  return 32'h7F800123;
            6:  return 32'hFFC00055;
            7:  return 32'h3F800000;
            8:  return 32'hBF800000;
            9:  return 32'h40000000;
            10: return 32'hC0400000;
            11: return 32'h3F000000;
            12: return 32'h00000001;
            13: return 32'h80000003;
            14: return 32'h7F7FFFFF;
            default: return 32'hC0000000;
        endcase
    endfunction

    function automatic bit f_nan(logic [31:0] v);
        return v[30:23] == 8'hFF && v[22:0] != 0;
    endfunction
    function automatic bit f_inf(logic [31:0] v);
        return v[30:0] == 31'h7F800000;
    endfunction
    function automatic bit f_zero(logic [31:0] v);
        return v[30:0] == 0;
    endfunction

    function automatic string tag_of(logic [31:0] y, logic [31:0] x);
        if (f_nan(x) || f_nan(y))  return "R1";
        if (f_inf(x))              return x[31] ? "R3" : "R2";
        if (f_inf(y))              return "R4";
        if (f_zero(x) && !f_zero(y)) return "R5";
        if (f_zero(y))             return "R6";
        return (y[30:0] > x[30:0]) ? "R8 R9" : "R7 R9";
    endfunction

    // expected {valid, final, result, swap, sub, neg, offset, num, den}
    function automatic logic [VW-1:0] model(logic [31:0] y, logic [31:0] x);
        logic [31:0] res;
        logic [31:0] off;
        logic        sw, sb;
        logic [30:0] n, d;
        if (f_nan(x)) begin
            res = x | 32'h00400000;
        end else if (f_nan(y)) begin
            res = y | 32'h00400000;
        end else if (f_inf(x)) begin
            if (!x[31]) res = f_inf(y) ? 32'h3F490FDB : 32'h0;
            else        res = f_inf(y) ? 32'h4016CBE4 : 32'h40490FDB;
            res[31] = y[31];
        end else if (f_inf(y) || (f_zero(x) && !f_zero(y))) begin
            res = {y[31], 31'h3FC90FDB};
        end else if (f_zero(y)) begin
            res = x[31] ? {y[31], 31'h40490FDB} : {y[31], 31'h0};
        end else begin
            sw = y[30:0] > x[30:0];
            n  = sw ? x[30:0] : y[30:0];
            d  = sw ? y[30:0] : x[30:0];
            if (sw) begin off = 32'h3FC90FDB; sb = !x[31]; end
            else    begin off = x[31] ? 32'h40490FDB : 32'h0; sb = x[31]; end
            return {1'b1, 1'b0, 32'h0, sw, sb, y[31], off, n, d};
        end
        return {1'b1, 1'b1, res, 1'b0, 1'b0, 1'b0, 32'h0, 31'h0, 31'h0};
    endfunction

    function automatic logic [VW-1:0] actual();
        return {out_valid, out_final, out_result, out_swap, out_sub, out_neg,
                out_offset, out_num, out_den};
    endfunction

    task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [VW-1:0] ref_a, ref_b;
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_y = '0; in_x = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", VW'({out_valid, in_ready}), VW'(2'b01));
        rst_n = 1'b1;

        // exhaustive pair sweep over the operand set
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                in_y = val(i); in_x = val(j); in_valid = 1'b1;
                @(negedge clk);
                in_valid = 1'b0;
                check(tag_of(in_y, in_x), actual(), model(in_y, in_x));
            end
        end

        // R10: back-pressure holds output and stalls input
        @(negedge clk);
        out_ready = 1'b0;
        in_y = 32'h3F800000; in_x = 32'h40000000; in_valid = 1'b1;
        ref_a = model(in_y, in_x);
        @(negedge clk);
        in_y = 32'h40000000; in_x = 32'hBF800000;
        ref_b = model(in_y, in_x);
        check("R10", VW'(in_ready), VW'(1'b0));
        check("R10", actual(), ref_a);
        @(negedge clk);
        check("R10", actual(), ref_a);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", actual(), ref_b);
        @(negedge clk);
        check("R10", VW'(out_valid), VW'(1'b0));

        finish_run();
    end
endmodule